// File: doc/BRIEF.md
# Dual Wiper Position Register with Write Gating

This block keeps the tap positions of two digitally controlled potentiometers. The first potentiometer has 100 taps and a 7-bit code; the second has 256 taps and an 8-bit code. A command decoder upstream presents single-cycle write requests. Each request names a potentiometer, says whether the write is volatile or nonvolatile, and carries a data byte. The block decides whether each request may proceed. It drives the live wiper codes, a copy of each wiper's nonvolatile shadow value, and a one-cycle rejection flag.

Three conditions set write permission. The first is a write-enable latch, which the decoder sets and clears. The second is a write-protect pin, which is inactive when low. The third is a lock bit. While the protect pin is high, every nonvolatile write is refused. If the lock bit is also 1, volatile writes to the wipers are refused as well. The shadow values survive a synchronous reset, and the reset reloads each live wiper from its shadow. This models the recall of stored positions at start-up. At power-up the shadows hold the parameters `SHADOW_A_INIT` (default 50) and `SHADOW_B_INIT` (default 128).

Top module: `dual_wiper_reg`

## Requirements
- R1: While `rst` is high, and after it falls, each wiper code equals its shadow code, `wr_rejected` is 0 and the write-enable latch is clear. After power-up the shadows are 50 (A) and 128 (B).
- R2: A request made while the write-enable latch is clear is rejected, whatever the other inputs are.
- R3: An accepted volatile request (`req_nv`=0) sets the selected wiper code on the next clock edge. It leaves both shadows and the other wiper unchanged. `req_pot`=0 selects potentiometer A and `req_pot`=1 selects potentiometer B.
- R4: An accepted nonvolatile request (`req_nv`=1) sets both the selected wiper code and its shadow code on the next clock edge.
- R5: While `wp_pin` is high, every nonvolatile request is rejected.
- R6: While `wp_pin` is high and `lock_bit` is 1, volatile requests are rejected. While `wp_pin` is high and `lock_bit` is 0, volatile requests are accepted.
- R7: While `wp_pin` is low, `lock_bit` has no effect on any request.
- R8: Data above 99 written to potentiometer A is stored as 99. Potentiometer B stores any value from 0 to 255 unchanged.
- R9: A rejected request changes no wiper or shadow code. It raises `wr_rejected` for exactly the one cycle after the request edge.
- R10: Shadow codes keep their value through `rst`. A reset after a nonvolatile write reloads the wiper with the written value and discards any later volatile change.
- R11: `wel_set` sets the latch and `wel_clr` clears it; when both are high, clearing wins. A request in the same cycle as `wel_set` is judged against the latch value before the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Write-protect pin, active high |
| lock_bit | input | 1 | Extends protection to volatile wiper writes |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch |
| req_valid | input | 1 | Write request strobe, one cycle per request |
| req_pot | input | 1 | Target: 0 = potentiometer A, 1 = potentiometer B |
| req_nv | input | 1 | 1 = nonvolatile write, 0 = volatile write |
| req_data | input | 8 | Requested wiper code |
| wiper_a_code | output | 7 | Live code of potentiometer A |
| wiper_b_code | output | 8 | Live code of potentiometer B |
| shadow_a_code | output | 7 | Nonvolatile shadow of potentiometer A |
| shadow_b_code | output | 8 | Nonvolatile shadow of potentiometer B |
| wr_rejected | output | 1 | Pulses for one cycle after a refused request |

## Verification
The hardest case to reach is a shadow that must outlive a reset. A nonvolatile write has to land first, and then a volatile write must move the wiper away from it. Only then does the reset show whether the reload uses the shadow rather than a constant or the last live value. The bench does this in that order, with the latch set beforehand. It then checks that the latch is clear after reset by issuing a request that must bounce. It also exercises the rule for a request in the same cycle as a latch set. It does this by driving `wel_set` and `req_valid` on the same edge.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int DATA_W = 8;

    typedef enum logic {
        POT_A = 1'b0,
        POT_B = 1'b1
    } pot_sel_e;

    typedef enum logic {
        WR_VOL = 1'b0,
        WR_NV  = 1'b1
    } wr_kind_e;

    typedef struct packed {
        logic              valid;
        pot_sel_e          pot;
        wr_kind_e          kind;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic              hit_a;
        logic              hit_b;
        wr_kind_e          kind;
        logic [DATA_W-1:0] data;
    } wr_grant_t;

    // Permission: latch must be set; protect pin blocks nonvolatile writes,
    // and blocks volatile ones too when the lock bit is set.
    function automatic logic write_allowed(input logic wel, input logic prot,
                                           input logic lock, input wr_kind_e kind);
        logic blocked;
        blocked = prot && ((kind == WR_NV) || lock);
        return wel && !blocked;
    endfunction

endpackage

// File: rtl/wel_latch.sv
module wel_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    always_ff @(posedge clk) begin
        if (rst)
            wel_o <= 1'b0;
        else if (clr_i)
            wel_o <= 1'b0;
        else if (set_i)
            wel_o <= 1'b1;
    end
endmodule

// File: rtl/wr_gate.sv
module wr_gate
    import wiper_pkg::*;
(
    input  wr_req_t   req_i,
    input  logic      wel_i,
    input  logic      prot_i,
    input  logic      lock_i,
    output wr_grant_t grant_o,
    output logic      reject_o
);
    logic ok;

    always_comb begin
        ok             = req_i.valid && write_allowed(wel_i, prot_i, lock_i, req_i.kind);
        grant_o.hit_a  = ok && (req_i.pot == POT_A);
        grant_o.hit_b  = ok && (req_i.pot == POT_B);
        grant_o.kind   = req_i.kind;
        grant_o.data   = req_i.data;
        reject_o       = req_i.valid && !ok;
    end
endmodule

// File: rtl/wiper_slot.sv
module wiper_slot
    import wiper_pkg::*;
#(
    parameter int TAPS = 100,
    parameter int INIT = 50,
    localparam int W        = $clog2(TAPS),
    localparam int MAX_CODE = TAPS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wr_kind_e          wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic [W-1:0]      wiper_o,
    output logic [W-1:0]      shadow_o
);
    logic [W-1:0] code;
    logic [W-1:0] wiper_q;
    logic [W-1:0] shadow_q = W'(INIT);

    generate
        if (MAX_CODE < (1 << DATA_W) - 1) begin : g_clamp
            logic [DATA_W-1:0] lim;
            always_comb begin
                lim  = (wr_data > DATA_W'(MAX_CODE)) ? DATA_W'(MAX_CODE) : wr_data;
                code = W'(lim);
            end
        end else begin : g_pass
            always_comb code = W'(wr_data);
        end
    endgenerate

    // Shadow is not cleared by rst: it models stored content.
    always_ff @(posedge clk) begin
        if (!rst && wr_en && (wr_kind == WR_NV))
            shadow_q <= code;
    end

    always_ff @(posedge clk) begin
        if (rst)
            wiper_q <= shadow_q;
        else if (wr_en)
            wiper_q <= code;
    end

    assign wiper_o  = wiper_q;
    assign shadow_o = shadow_q;
endmodule

// File: rtl/dual_wiper_reg.sv
module dual_wiper_reg
    import wiper_pkg::*;
#(
    parameter int TAPS_A        = 100,
    parameter int TAPS_B        = 256,
    parameter int SHADOW_A_INIT = 50,
    parameter int SHADOW_B_INIT = 128
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wp_pin,
    input  logic                      lock_bit,
    input  logic                      wel_set,
    input  logic                      wel_clr,
    input  logic                      req_valid,
    input  logic                      req_pot,
    input  logic                      req_nv,
    input  logic [7:0]                req_data,
    output logic [$clog2(TAPS_A)-1:0] wiper_a_code,
    output logic [$clog2(TAPS_B)-1:0] wiper_b_code,
    output logic [$clog2(TAPS_A)-1:0] shadow_a_code,
    output logic [$clog2(TAPS_B)-1:0] shadow_b_code,
    output logic                      wr_rejected
);
    wr_req_t   req;
    wr_grant_t grant;
    logic      wel_q;
    logic      reject;
    logic      rej_q;

    always_comb begin
        req.valid = req_valid;
        req.pot   = pot_sel_e'(req_pot);
        req.kind  = wr_kind_e'(req_nv);
        req.data  = req_data;
    end

    wel_latch u_wel (
        .clk   (clk),
        .rst   (rst),
        .set_i (wel_set),
        .clr_i (wel_clr),
        .wel_o (wel_q)
    );

    wr_gate u_gate (
        .req_i    (req),
        .wel_i    (wel_q),
        .prot_i   (wp_pin),
        .lock_i   (lock_bit),
        .grant_o  (grant),
        .reject_o (reject)
    );

    wiper_slot #(.TAPS(TAPS_A), .INIT(SHADOW_A_INIT)) u_slot_a (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (grant.hit_a),
        .wr_kind  (grant.kind),
        .wr_data  (grant.data),
        .wiper_o  (wiper_a_code),
        .shadow_o (shadow_a_code)
    );

    wiper_slot #(.TAPS(TAPS_B), .INIT(SHADOW_B_INIT)) u_slot_b (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (grant.hit_b),
        .wr_kind  (grant.kind),
        .wr_data  (grant.data),
        .wiper_o  (wiper_b_code),
        .shadow_o (shadow_b_code)
    );

    always_ff @(posedge clk) begin
        if (rst) rej_q <= 1'b0;
        else     rej_q <= reject;
    end

    assign wr_rejected = rej_q;
endmodule

// File: rtl/dual_wiper_reg_chk.sv
module dual_wiper_reg_chk #(
    parameter int TAPS_A = 100,
    parameter int TAPS_B = 256
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wp_pin,
    input logic                      lock_bit,
    input logic                      req_valid,
    input logic                      req_nv,
    input logic                      wel_q,
    input logic [$clog2(TAPS_A)-1:0] wiper_a_code,
    input logic [$clog2(TAPS_B)-1:0] wiper_b_code,
    input logic [$clog2(TAPS_A)-1:0] shadow_a_code,
    input logic [$clog2(TAPS_B)-1:0] shadow_b_code,
    input logic                      wr_rejected
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    p_reset_reload_r1: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (wiper_a_code == shadow_a_code) && (wiper_b_code == shadow_b_code) && !wr_rejected);

    p_need_wel_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !wel_q) |=> wr_rejected);

    p_vol_keeps_shadow_r3: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_nv) |=> $stable(shadow_a_code) && $stable(shadow_b_code));

    p_nv_protected_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_nv && wp_pin) |=> wr_rejected);

    p_lock_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_nv && wp_pin && lock_bit) |=> wr_rejected);

    p_clamp_a_r8: assert property (@(posedge clk) disable iff (rst)
        (32'(wiper_a_code) <= TAPS_A - 1) && (32'(shadow_a_code) <= TAPS_A - 1));

    p_reject_no_change_r9: assert property (@(posedge clk) disable iff (rst)
        wr_rejected |-> $stable(wiper_a_code) && $stable(wiper_b_code)
                        && $stable(shadow_a_code) && $stable(shadow_b_code));

    p_reject_only_after_req_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !wr_rejected);
endmodule

bind dual_wiper_reg dual_wiper_reg_chk #(.TAPS_A(TAPS_A), .TAPS_B(TAPS_B)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wp_pin        (wp_pin),
    .lock_bit      (lock_bit),
    .req_valid     (req_valid),
    .req_nv        (req_nv),
    .wel_q         (wel_q),
    .wiper_a_code  (wiper_a_code),
    .wiper_b_code  (wiper_b_code),
    .shadow_a_code (shadow_a_code),
    .shadow_b_code (shadow_b_code),
    .wr_rejected   (wr_rejected)
);

// File: tb/dual_wiper_reg_bench.sv
`timescale 1ns/1ps
module dual_wiper_reg_bench;
    logic       clk = 1'b0;
    logic       rst, wp_pin, lock_bit, wel_set, wel_clr;
    logic       req_valid, req_pot, req_nv;
    logic [7:0] req_data;
    logic [6:0] wiper_a_code, shadow_a_code;
    logic [7:0] wiper_b_code, shadow_b_code;
    logic       wr_rejected;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_wa, exp_wb, exp_sa, exp_sb;
    logic exp_wel;

    always #4 clk = ~clk;

    dual_wiper_reg u_dual_wiper_reg (
        .clk(clk), .rst(rst), .wp_pin(wp_pin), .lock_bit(lock_bit),
        .wel_set(wel_set), .wel_clr(wel_clr), .req_valid(req_valid),
        .req_pot(req_pot), .req_nv(req_nv), .req_data(req_data),
        .wiper_a_code(wiper_a_code), .wiper_b_code(wiper_b_code),
        .shadow_a_code(shadow_a_code), .shadow_b_code(shadow_b_code),
        .wr_rejected(wr_rejected)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "wiper A", int'(wiper_a_code), exp_wa);
        chk(req, "wiper B", int'(wiper_b_code), exp_wb);
        chk(req, "shadow A", int'(shadow_a_code), exp_sa);
        chk(req, "shadow B", int'(shadow_b_code), exp_sb);
    endtask

    task automatic wel(input logic s, input logic c);
        @(negedge clk);
        wel_set = s; wel_clr = c;
        @(negedge clk);
        wel_set = 1'b0; wel_clr = 1'b0;
        if (c) exp_wel = 1'b0; else if (s) exp_wel = 1'b1;
    endtask

    // One request; expected result from the permission rules.
    task automatic issue(input string req, input logic pot, input logic nv, input int d,
                         input logic prot, input logic lock);
        logic ok;
        int code;
        @(negedge clk);
        wp_pin = prot; lock_bit = lock;
        req_valid = 1'b1; req_pot = pot; req_nv = nv; req_data = d[7:0];
        ok = exp_wel && !(prot && (nv || lock));
        code = (pot == 1'b0 && d > 99) ? 99 : d;
        @(negedge clk);
        req_valid = 1'b0;
        if (ok) begin
            if (pot == 1'b0) begin exp_wa = code; if (nv) exp_sa = code; end
            else             begin exp_wb = code; if (nv) exp_sb = code; end
        end
        chk(req, "rejected flag", int'(wr_rejected), ok ? 0 : 1);
        chk_state(req);
        @(negedge clk);
        chk(req, "flag one cycle", int'(wr_rejected), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_wa = exp_sa; exp_wb = exp_sb; exp_wel = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "flag after reset", int'(wr_rejected), 0);
        chk_state("R1");
        issue("R1", 1'b0, 1'b0, 7, 1'b0, 1'b0);
    endtask

    task automatic t_no_wel();
        issue("R2", 1'b1, 1'b0, 9, 1'b0, 1'b0);
        issue("R9", 1'b0, 1'b1, 11, 1'b0, 1'b0);
    endtask

    task automatic t_volatile();
        wel(1'b1, 1'b0);
        issue("R3", 1'b0, 1'b0, 20, 1'b0, 1'b0);
        issue("R3", 1'b1, 1'b0, 200, 1'b0, 1'b0);
    endtask

    task automatic t_nonvolatile();
        issue("R4", 1'b0, 1'b1, 33, 1'b0, 1'b0);
        issue("R4", 1'b1, 1'b1, 7, 1'b0, 1'b0);
    endtask

    task automatic t_protect();
        issue("R5", 1'b0, 1'b1, 60, 1'b1, 1'b0);
        issue("R5", 1'b1, 1'b1, 61, 1'b1, 1'b1);
        issue("R6", 1'b0, 1'b0, 44, 1'b1, 1'b0);
        issue("R6", 1'b1, 1'b0, 45, 1'b1, 1'b1);
        issue("R6", 1'b0, 1'b0, 46, 1'b1, 1'b1);
    endtask

    task automatic t_lock_only();
        issue("R7", 1'b1, 1'b0, 150, 1'b0, 1'b1);
        issue("R7", 1'b0, 1'b1, 12, 1'b0, 1'b1);
    endtask

    task automatic t_clamp();
        issue("R8", 1'b0, 1'b0, 100, 1'b0, 1'b0);
        issue("R8", 1'b0, 1'b0, 98, 1'b0, 1'b0);
        issue("R8", 1'b0, 1'b1, 255, 1'b0, 1'b0);
        issue("R8", 1'b0, 1'b0, 99, 1'b0, 1'b0);
        issue("R8", 1'b1, 1'b0, 255, 1'b0, 1'b0);
        issue("R8", 1'b1, 1'b1, 0, 1'b0, 1'b0);
    endtask

    task automatic t_reload();
        issue("R10", 1'b0, 1'b1, 33, 1'b0, 1'b0);
        issue("R10", 1'b0, 1'b0, 5, 1'b0, 1'b0);
        issue("R10", 1'b1, 1'b0, 77, 1'b0, 1'b0);
        do_reset();
        chk_state("R10");
        issue("R1", 1'b0, 1'b0, 3, 1'b0, 1'b0);
    endtask

    task automatic t_wel_rules();
        wel(1'b1, 1'b1);
        issue("R11", 1'b0, 1'b0, 8, 1'b0, 1'b0);
        @(negedge clk);
        wel_set = 1'b1; req_valid = 1'b1; req_pot = 1'b0; req_nv = 1'b0; req_data = 8'd8;
        @(negedge clk);
        wel_set = 1'b0; req_valid = 1'b0; exp_wel = 1'b1;
        chk("R11", "same-cycle set rejected", int'(wr_rejected), 1);
        chk_state("R11");
        issue("R11", 1'b0, 1'b0, 8, 1'b0, 1'b0);
        wel(1'b0, 1'b1);
        issue("R11", 1'b1, 1'b0, 9, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wp_pin = 1'b0; lock_bit = 1'b0; wel_set = 1'b0; wel_clr = 1'b0;
        req_valid = 1'b0; req_pot = 1'b0; req_nv = 1'b0; req_data = 8'd0;
        exp_wa = 50; exp_sa = 50; exp_wb = 128; exp_sb = 128; exp_wel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_no_wel();
        t_volatile();
        t_nonvolatile();
        t_protect();
        t_lock_only();
        t_clamp();
        t_reload();
        t_wel_rules();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule